// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer with Loop Counter

This block generates the next microinstruction address for a microprogrammed controller. Each cycle it reads a 4-bit sequencing opcode from the pipeline register of the microword, together with a branch field, an address supplied by an external mapping unit and a test condition. From these it forms the next microaddress. That address is presented combinationally to the microprogram memory and is captured into the current-address register on the rising clock edge.

A built-in down-counter supports counted loops. One opcode loads the counter from the branch field. A repeat opcode jumps back to the branch target and decrements the counter until the counter reaches zero, and then falls through. The other opcodes are a plain increment, a jump to the mapped address, a conditional jump whose test polarity is chosen per microword, and a jump to address zero that serves as the initialise path. The block has no stack and stores no microcode. Its pins are plain control signals, with no handshake, because the sequencer advances on every clock.

Top module: `useq_top`

## Requirements
- R1: While the synchronous reset `rst` is high at a rising edge, the current address and the loop counter both become zero at that edge.
- R2: At every rising edge outside reset, `cur_addr` takes the value that `next_addr` showed just before the edge. `next_addr` follows the present inputs and state without a clock delay.
- R3: Opcode 1 (advance) and every opcode from 6 to 15 give `next_addr = cur_addr + 1`.
- R4: Opcode 2 (load counter) loads the loop counter from the low counter-width bits of `branch_in` and gives `next_addr = cur_addr + 1`.
- R5: Opcode 3 (repeat) with a non-zero counter gives `next_addr = branch_in` and decrements the counter by one at the edge.
- R6: Opcode 3 (repeat) with the counter at zero gives `next_addr = cur_addr + 1` and leaves the counter at zero.
- R7: Opcode 4 (map jump) gives `next_addr = map_in`, regardless of the condition inputs.
- R8: Opcode 5 (conditional jump) tests `cond_in XOR cond_pol`. When that value is 1 it gives `next_addr = branch_in`. Otherwise it gives `cur_addr + 1`.
- R9: Opcode 0 (zero jump) gives `next_addr = 0`.
- R10: The loop counter keeps its value under every opcode other than 2 and 3.
- R11: The address increment wraps from the all-ones address to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| op | input | 4 | Sequencing opcode from the microword |
| branch_in | input | DW (8) | Branch target; also the counter load value |
| map_in | input | AW (8) | Address from the external mapping unit |
| cond_in | input | 1 | Test condition |
| cond_pol | input | 1 | 1 inverts the condition before the test |
| next_addr | output | AW (8) | Combinational next microaddress |
| cur_addr | output | AW (8) | Registered current microaddress |
| loop_count | output | CW (8) | Loop counter value |

## Verification
The hard cases are the edges of the loop counter. The bench runs a counted loop from a small microprogram and expects the body to execute one more time than the loaded count. A design that tested the counter after decrementing would execute the body one time too few. A design that decremented at zero would wrap the counter and loop almost forever. The bench also drives both settings of the polarity bit on both condition values, so an inverted test sends the conditional jump the wrong way. It drives undefined opcodes, where a careless decoder would jump or disturb the counter. Last, it steps the address across the all-ones boundary to expose an increment that does not wrap.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int unsigned OP_W = 4;

  localparam logic [OP_W-1:0] OP_ZERO = 4'd0;
  localparam logic [OP_W-1:0] OP_NEXT = 4'd1;
  localparam logic [OP_W-1:0] OP_LOAD = 4'd2;
  localparam logic [OP_W-1:0] OP_LOOP = 4'd3;
  localparam logic [OP_W-1:0] OP_MAP  = 4'd4;
  localparam logic [OP_W-1:0] OP_COND = 4'd5;

  typedef enum logic [1:0] {
    SRC_INC  = 2'd0,
    SRC_BR   = 2'd1,
    SRC_MAP  = 2'd2,
    SRC_ZERO = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_LOAD = 2'd1,
    CNT_DEC  = 2'd2
  } cact_e;
endpackage

// File: rtl/useq_decode.sv
module useq_decode
  import useq_pkg::*;
(
  input  logic [OP_W-1:0] op,
  input  logic            cond_in,
  input  logic            cond_pol,
  input  logic            cnt_zero,
  output src_e            src,
  output cact_e           cact
);
  logic cond_pass;
  assign cond_pass = cond_in ^ cond_pol;

  always_comb begin
    src  = SRC_INC;
    cact = CNT_HOLD;
    unique case (op)
      OP_ZERO: src = SRC_ZERO;
      OP_LOAD: cact = CNT_LOAD;
      OP_LOOP: begin
        if (!cnt_zero) begin
          src  = SRC_BR;
          cact = CNT_DEC;
        end
      end
      OP_MAP:  src = SRC_MAP;
      OP_COND: if (cond_pass) src = SRC_BR;
      default: ;
    endcase
  end
endmodule

// File: rtl/useq_counter.sv
module useq_counter
  import useq_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  cact_e         cact,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] count,
  output logic          zero
);
  localparam logic [CW-1:0] ONE = CW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else begin
      case (cact)
        CNT_LOAD: count <= load_val;
        CNT_DEC:  count <= count - ONE;
        default:  count <= count;
      endcase
    end
  end

  assign zero = (count == '0);
endmodule

// File: rtl/useq_addr.sv
module useq_addr
  import useq_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  src_e          src,
  input  logic [AW-1:0] branch,
  input  logic [AW-1:0] map,
  output logic [AW-1:0] next_addr,
  output logic [AW-1:0] cur_addr
);
  localparam logic [AW-1:0] ONE = AW'(1);
  logic [AW-1:0] incr;

  assign incr = cur_addr + ONE;

  always_comb begin
    case (src)
      SRC_BR:   next_addr = branch;
      SRC_MAP:  next_addr = map;
      SRC_ZERO: next_addr = '0;
      default:  next_addr = incr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cur_addr <= '0;
    else     cur_addr <= next_addr;
  end
endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned CW = 8,
  localparam int unsigned DW = (AW > CW) ? AW : CW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] op,
  input  logic [DW-1:0]   branch_in,
  input  logic [AW-1:0]   map_in,
  input  logic            cond_in,
  input  logic            cond_pol,
  output logic [AW-1:0]   next_addr,
  output logic [AW-1:0]   cur_addr,
  output logic [CW-1:0]   loop_count
);
  src_e  src;
  cact_e cact;
  logic  cnt_zero;

  useq_decode u_dec (
    .op       (op),
    .cond_in  (cond_in),
    .cond_pol (cond_pol),
    .cnt_zero (cnt_zero),
    .src      (src),
    .cact     (cact)
  );

  useq_counter #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .cact     (cact),
    .load_val (branch_in[CW-1:0]),
    .count    (loop_count),
    .zero     (cnt_zero)
  );

  useq_addr #(.AW(AW)) u_addr (
    .clk       (clk),
    .rst       (rst),
    .src       (src),
    .branch    (branch_in[AW-1:0]),
    .map       (map_in),
    .next_addr (next_addr),
    .cur_addr  (cur_addr)
  );
endmodule

// File: rtl/useq_checker.sv
module useq_checker
  import useq_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned CW = 8,
  parameter int unsigned DW = 8
) (
  input logic            clk,
  input logic            rst,
  input logic [OP_W-1:0] op,
  input logic [DW-1:0]   branch_in,
  input logic [AW-1:0]   map_in,
  input logic            cond_in,
  input logic            cond_pol,
  input logic [AW-1:0]   next_addr,
  input logic [AW-1:0]   cur_addr,
  input logic [CW-1:0]   loop_count
);
  localparam logic [AW-1:0] A1 = AW'(1);
  localparam logic [CW-1:0] C1 = CW'(1);

  logic past_rst;
  always_ff @(posedge clk) past_rst <= rst;

  always @(posedge clk) begin
    if (past_rst === 1'b1) begin
      p_reset_clear_r1: assert (cur_addr == '0 && loop_count == '0)
        else $error("R1 reset state");
    end
  end

  p_follow_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cur_addr == $past(next_addr));

  p_load_r4: assert property (@(posedge clk) disable iff (rst)
    op == OP_LOAD |=> loop_count == $past(branch_in[CW-1:0]));

  p_loop_take_r5: assert property (@(posedge clk) disable iff (rst)
    (op == OP_LOOP && loop_count != '0) |-> next_addr == branch_in[AW-1:0]);

  p_loop_dec_r5: assert property (@(posedge clk) disable iff (rst)
    (op == OP_LOOP && loop_count != '0) |=> loop_count == $past(loop_count) - C1);

  p_loop_exit_r6: assert property (@(posedge clk) disable iff (rst)
    (op == OP_LOOP && loop_count == '0) |-> next_addr == cur_addr + A1);

  p_map_r7: assert property (@(posedge clk) disable iff (rst)
    op == OP_MAP |-> next_addr == map_in);

  p_cond_r8: assert property (@(posedge clk) disable iff (rst)
    (op == OP_COND && (cond_in ^ cond_pol)) |-> next_addr == branch_in[AW-1:0]);

  p_zero_r9: assert property (@(posedge clk) disable iff (rst)
    op == OP_ZERO |-> next_addr == '0);

  p_cnt_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (op != OP_LOAD && op != OP_LOOP) |=> $stable(loop_count));
endmodule

bind useq_top useq_checker #(.AW(AW), .CW(CW), .DW(DW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .op         (op),
  .branch_in  (branch_in),
  .map_in     (map_in),
  .cond_in    (cond_in),
  .cond_pol   (cond_pol),
  .next_addr  (next_addr),
  .cur_addr   (cur_addr),
  .loop_count (loop_count)
);

// File: tb/useq_top_test.sv
`timescale 1ns/1ps
module useq_top_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] op = 4'd1;
  logic [7:0] branch_in = '0;
  logic [7:0] map_in = '0;
  logic       cond_in = 1'b0;
  logic       cond_pol = 1'b0;
  logic [7:0] next_addr, cur_addr, loop_count;

  int errors = 0;
  int checks = 0;
  int m_pc = 0;
  int m_cnt = 0;

  logic [3:0] pm_op [256];
  logic [7:0] pm_br [256];
  logic [7:0] pm_map [256];
  logic       pm_c [256];
  logic       pm_p [256];

  always #2 clk = ~clk;

  useq_top uut (
    .clk(clk), .rst(rst), .op(op), .branch_in(branch_in), .map_in(map_in),
    .cond_in(cond_in), .cond_pol(cond_pol),
    .next_addr(next_addr), .cur_addr(cur_addr), .loop_count(loop_count)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      4'd0: return "R9 zero jump";
      4'd1: return "R3 advance";
      4'd2: return "R4 load counter";
      4'd3: return (m_cnt != 0) ? "R5 repeat taken" : "R6 repeat exit";
      4'd4: return "R7 map jump";
      4'd5: return "R8 conditional jump";
      default: return "R3 undefined opcode";
    endcase
  endfunction

  function automatic int model_next(input logic [3:0] o, input int br, input int mp,
                                    input logic c, input logic p);
    int inc;
    inc = (m_pc + 1) % 256;   // R11 wrap
    case (o)
      4'd0: return 0;
      4'd2: return inc;
      4'd3: return (m_cnt != 0) ? br : inc;
      4'd4: return mp;
      4'd5: return (c ^ p) ? br : inc;
      default: return inc;
    endcase
  endfunction

  // one cycle: called just after a falling edge
  task automatic step(input logic [3:0] o, input logic [7:0] br, input logic [7:0] mp,
                      input logic c, input logic p, input logic r);
    int exp_next;
    op = o; branch_in = br; map_in = mp; cond_in = c; cond_pol = p; rst = r;
    #1;
    exp_next = model_next(o, br, mp, c, p);
    check(next_addr == exp_next[7:0], tag_of(o), next_addr, exp_next);
    @(posedge clk);
    if (r) begin
      m_pc = 0; m_cnt = 0;
    end else begin
      m_pc = exp_next;
      if (o == 4'd2) m_cnt = br;
      else if (o == 4'd3 && m_cnt != 0) m_cnt = m_cnt - 1;
    end
    @(negedge clk);
    check(cur_addr == m_pc[7:0], r ? "R1 reset address" : "R2 address register", cur_addr, m_pc);
    check(loop_count == m_cnt[7:0], r ? "R1 reset counter" : "R10 counter", loop_count, m_cnt);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int visits;
    for (int i = 0; i < 256; i++) begin
      pm_op[i] = 4'd1; pm_br[i] = '0; pm_map[i] = '0; pm_c[i] = 0; pm_p[i] = 0;
    end
    // counted loop program
    pm_op[0] = 4'd2; pm_br[0] = 8'd3;
    pm_op[2] = 4'd3; pm_br[2] = 8'd1;
    pm_op[3] = 4'd4; pm_map[3] = 8'd10;
    pm_op[10] = 4'd5; pm_br[10] = 8'd40; pm_c[10] = 1; pm_p[10] = 1;
    pm_op[11] = 4'd5; pm_br[11] = 8'd14; pm_c[11] = 0; pm_p[11] = 1;
    pm_op[14] = 4'd0;

    @(negedge clk);
    step(4'd7, 8'h55, 8'haa, 1, 0, 1);
    step(4'd1, 8'h00, 8'h00, 0, 0, 1);
    check(cur_addr == 8'd0, "R1 reset address", cur_addr, 0);
    check(loop_count == 8'd0, "R1 reset counter", loop_count, 0);

    // microprogram run: body at address 1 must execute loaded count + 1 times
    visits = 0;
    for (int k = 0; k < 13; k++) begin
      if (cur_addr == 8'd1) visits++;
      step(pm_op[m_pc], pm_br[m_pc], pm_map[m_pc], pm_c[m_pc], pm_p[m_pc], 0);
    end
    check(visits == 4, "R5 R6 loop body passes", visits, 4);
    check(cur_addr == 8'd0, "R9 program returned to zero", cur_addr, 0);

    // condition polarity, all four combinations
    step(4'd5, 8'd90, 8'd0, 1, 0, 0);
    step(4'd5, 8'd20, 8'd0, 0, 0, 0);
    step(4'd5, 8'd30, 8'd0, 0, 1, 0);
    step(4'd5, 8'd40, 8'd0, 1, 1, 0);

    // wrap of the increment
    step(4'd4, 8'd0, 8'd254, 0, 0, 0);
    step(4'd1, 8'd0, 8'd0, 0, 0, 0);
    step(4'd1, 8'd0, 8'd0, 0, 0, 0);
    check(cur_addr == 8'd0, "R11 increment wrap", cur_addr, 0);

    // repeat with counter zero, then undefined opcodes keep counter
    step(4'd3, 8'd77, 8'd0, 0, 0, 0);
    step(4'd2, 8'd5, 8'd0, 0, 0, 0);
    for (int u = 6; u < 16; u++) step(u[3:0], 8'd200, 8'd100, 1, 0, 0);
    check(loop_count == 8'd5, "R10 undefined opcodes keep counter", loop_count, 5);
    step(4'd4, 8'd9, 8'd123, 1, 1, 0);

    // mixed random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [3:0] ro;
      ro = ($urandom % 3 == 0) ? 4'($urandom % 16) : 4'($urandom % 6);
      step(ro, 8'($urandom % 8), 8'($urandom), 1'($urandom), 1'($urandom),
           ($urandom % 200) == 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule